// File: doc/BRIEF.md
# Adaptive Recharge Period Scheduler

This block decides when a regulator recharge pulse is due while the chip sits in a low-power mode. A slow tick, about 32 kHz, is the time base. Two compact codes set the timing. Each code has a 5-bit mantissa `m` and a 3-bit exponent `e`, and it stands for `(m*16+15) << e` ticks. One code gives the starting interval and the other gives the ceiling that the interval may never pass.

Before each recharge fires, the block samples a comparator input that reports whether the supply is still above its threshold. With adaptation on, a good sample stretches the interval and a bad sample shrinks it. The step is the interval scaled by the sum of two programmable power-of-two fractions. The block also keeps two status values: a short history of recent samples, and the longest interval that still ended with a good sample. A clear strobe zeroes the second one.

The surrounding power controller raises `pd_mode` for the duration of the low-power state. It forwards every `rchg_req` pulse to the regulator and reads the status outputs when convenient.

Top module: `recharge_sched`

## Requirements
- R1: A code (m, e) stands for (m*16+15)<<e ticks. After `pd_mode` rises and one clock passes, `rchg_req` pulses high for exactly one clock after the N-th `tick`, where N is the current interval. It then pulses again every N ticks.
- R2: The interval in use never exceeds the ceiling decoded from `cap_man`/`cap_exp`. A starting interval above the ceiling is clamped to the ceiling.
- R3: With `adapt_en`=1, each recharge turns interval P into P+D when `supply_ok`=1 and into P-D when `supply_ok`=0, where D=(P>>`gain_a`)+(P>>`gain_b`). The result is clamped to the ceiling (R2) and to the floor (R10).
- R4: When D is zero, or when `adapt_en`=0, the interval is left unchanged by a recharge.
- R5: At each recharge `sample_hist` shifts left by one bit and takes the `supply_ok` value in bit 0.
- R6: At a recharge with `supply_ok`=1, `peak_safe` becomes the larger of itself and the interval that just ended. Otherwise `peak_safe` never decreases, except that `peak_clr` sets it to 0 on the next clock, and `peak_clr` wins over a same-cycle update.
- R7: Each new rise of `pd_mode` reloads the starting interval, dropping any adapted value.
- R8: With `cap_man`=31, `cap_exp`=7 and `adapt_en`=0, no recharge is ever issued.
- R9: While `pd_mode`=0 no recharge is issued and ticks are ignored. `sample_hist` and `peak_safe` hold their values.
- R10: The interval in use during powerdown is never below 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse per slow-clock period |
| pd_mode | input | 1 | High while the low-power mode is active |
| adapt_en | input | 1 | Enables interval adaptation |
| gain_a | input | 4 | First gain shift (valid 1..10) |
| gain_b | input | 4 | Second gain shift (valid 2..10) |
| init_man | input | 5 | Starting interval mantissa |
| init_exp | input | 3 | Starting interval exponent |
| cap_man | input | 5 | Ceiling mantissa |
| cap_exp | input | 3 | Ceiling exponent |
| supply_ok | input | 1 | Comparator: supply above threshold |
| peak_clr | input | 1 | Strobe that zeroes `peak_safe` |
| rchg_req | output | 1 | One-clock recharge request |
| sample_hist | output | 4 | Last four samples, newest in bit 0 |
| peak_safe | output | 16 | Longest interval that ended with a good sample |

## Verification
The adapted interval is never visible at the ports, so it is hard to observe directly. The bench recovers it by counting ticks between two consecutive recharge pulses. Each scenario therefore runs two or three full intervals in a row, and it sets `supply_ok` before the final tick of each interval. That way one scenario can steer an upward step, a downward step, a clamped step at the ceiling and a zero step. The disabled configuration and idle mode are checked by running many ticks and watching for any pulse at all.

// File: rtl/rchg_pkg.sv
package rchg_pkg;
    localparam int MAN_W  = 5;
    localparam int EXP_W  = 3;
    localparam int PER_W  = 16;
    localparam int GAIN_W = 4;
    localparam int HIST_W = 4;

    typedef struct packed {
        logic              active;
        logic [PER_W-1:0]  period;
        logic [PER_W-1:0]  cnt;
        logic [HIST_W-1:0] hist;
        logic [PER_W-1:0]  peak;
        logic              req;
    } sched_state_t;
endpackage

// File: rtl/rchg_code2ticks.sv
module rchg_code2ticks
    import rchg_pkg::*;
#(
    parameter int MW = MAN_W,
    parameter int EW = EXP_W,
    parameter int PW = PER_W
) (
    input  logic [MW-1:0] man,
    input  logic [EW-1:0] expo,
    output logic [PW-1:0] ticks
);
    localparam int BASE_W = MW + 4;
    logic [BASE_W-1:0] base;
    always_comb begin
        base  = {man, 4'hF};
        ticks = PW'(base) << expo;
    end
endmodule

// File: rtl/rchg_gain.sv
module rchg_gain
    import rchg_pkg::*;
#(
    parameter int PW = PER_W,
    parameter int GW = GAIN_W
) (
    input  logic [PW-1:0] period,
    input  logic [GW-1:0] sh_a,
    input  logic [GW-1:0] sh_b,
    input  logic          grow,
    input  logic [PW-1:0] cap,
    output logic [PW-1:0] next_period
);
    localparam int SW = PW + 1;
    logic [SW-1:0] delta;
    logic [SW-1:0] sum;
    always_comb begin
        delta = SW'(period >> sh_a) + SW'(period >> sh_b);
        sum   = SW'(period) + delta;
        if (grow) begin
            next_period = (sum > SW'(cap)) ? cap : sum[PW-1:0];
        end else if (delta >= SW'(period)) begin
            next_period = PW'(1);
        end else begin
            next_period = period - delta[PW-1:0];
        end
        if (next_period == '0) next_period = PW'(1);
    end
endmodule

// File: rtl/recharge_sched.sv
module recharge_sched
    import rchg_pkg::*;
#(
    parameter int MW = MAN_W,
    parameter int EW = EXP_W,
    parameter int PW = PER_W,
    parameter int GW = GAIN_W,
    parameter int HW = HIST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pd_mode,
    input  logic          adapt_en,
    input  logic [GW-1:0] gain_a,
    input  logic [GW-1:0] gain_b,
    input  logic [MW-1:0] init_man,
    input  logic [EW-1:0] init_exp,
    input  logic [MW-1:0] cap_man,
    input  logic [EW-1:0] cap_exp,
    input  logic          supply_ok,
    input  logic          peak_clr,
    output logic          rchg_req,
    output logic [HW-1:0] sample_hist,
    output logic [15:0]   peak_safe
);
    localparam logic [MW-1:0] MAN_ALL = '1;
    localparam logic [EW-1:0] EXP_ALL = '1;
    localparam int NCODE = 2;

    sched_state_t s_d, s_q;

    logic [MW-1:0] code_man [NCODE];
    logic [EW-1:0] code_exp [NCODE];
    logic [PW-1:0] code_ticks [NCODE];

    always_comb begin
        code_man[0] = init_man;
        code_exp[0] = init_exp;
        code_man[1] = cap_man;
        code_exp[1] = cap_exp;
    end

    for (genvar gi = 0; gi < NCODE; gi++) begin : g_dec
        rchg_code2ticks #(.MW(MW), .EW(EW), .PW(PW)) dec_i (
            .man  (code_man[gi]),
            .expo (code_exp[gi]),
            .ticks(code_ticks[gi])
        );
    end

    logic [PW-1:0] start_ticks, cap_ticks, start_clamped, adapted;
    logic          sched_off, fire;

    assign start_ticks   = code_ticks[0];
    assign cap_ticks     = code_ticks[1];
    assign start_clamped = (start_ticks > cap_ticks) ? cap_ticks : start_ticks;
    assign sched_off     = (cap_man == MAN_ALL) && (cap_exp == EXP_ALL) && !adapt_en;

    rchg_gain #(.PW(PW), .GW(GW)) gain_i (
        .period     (s_q.period),
        .sh_a       (gain_a),
        .sh_b       (gain_b),
        .grow       (supply_ok),
        .cap        (cap_ticks),
        .next_period(adapted)
    );

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        fire    = 1'b0;
        if (!pd_mode) begin
            s_d.active = 1'b0;
            s_d.period = '0;
            s_d.cnt    = '0;
        end else if (!s_q.active) begin
            s_d.active = 1'b1;
            s_d.period = start_clamped;
            s_d.cnt    = start_clamped;
        end else if (tick && !sched_off) begin
            if (s_q.cnt <= PW'(1)) begin
                fire = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - PW'(1);
            end
        end
        if (fire) begin
            s_d.req  = 1'b1;
            s_d.hist = {s_q.hist[HW-2:0], supply_ok};
            if (supply_ok && (s_q.period > s_q.peak)) s_d.peak = s_q.period;
            s_d.period = adapt_en ? adapted : s_q.period;
            s_d.cnt    = adapt_en ? adapted : s_q.period;
        end
        if (peak_clr) s_d.peak = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [PW-1:0] cur_period;
    logic          run_active;
    assign cur_period  = s_q.period;
    assign run_active  = s_q.active;
    assign rchg_req    = s_q.req;
    assign sample_hist = s_q.hist;
    assign peak_safe   = 16'(s_q.peak);
endmodule

// File: rtl/recharge_sched_chk.sv
module recharge_sched_chk #(
    parameter int PW = 16,
    parameter int HW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          pd_mode,
    input logic          supply_ok,
    input logic          peak_clr,
    input logic          rchg_req,
    input logic [HW-1:0] sample_hist,
    input logic [15:0]   peak_safe,
    input logic [PW-1:0] cur_period,
    input logic [PW-1:0] cap_ticks,
    input logic          run_active
);
    assert_req_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rchg_req |-> $past(tick) && $past(pd_mode));

    assert_under_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && pd_mode && $stable(cap_ticks)) |-> cur_period <= cap_ticks);

    assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rchg_req |-> (sample_hist[HW-1:1] == $past(sample_hist[HW-2:0]))
                     && (sample_hist[0] == $past(supply_ok)));

    assert_peak_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        peak_clr |=> peak_safe == 16'd0);

    assert_peak_no_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(peak_clr) |-> peak_safe >= $past(peak_safe));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_mode |=> !rchg_req);

    assert_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_active |-> cur_period != '0);
endmodule

bind recharge_sched recharge_sched_chk #(.PW(PW), .HW(HW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pd_mode    (pd_mode),
    .supply_ok  (supply_ok),
    .peak_clr   (peak_clr),
    .rchg_req   (rchg_req),
    .sample_hist(sample_hist),
    .peak_safe  (peak_safe),
    .cur_period (cur_period),
    .cap_ticks  (cap_ticks),
    .run_active (run_active)
);

// File: tb/recharge_sched_tb_top.sv
module recharge_sched_tb_top;
    localparam time CLK_PER = 10ns;
    localparam int  WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, pd_mode = 1'b0, adapt_en = 1'b0;
    logic [3:0]  gain_a = 4'd1, gain_b = 4'd2;
    logic [4:0]  init_man = '0, cap_man = 5'd31;
    logic [2:0]  init_exp = '0, cap_exp = 3'd6;
    logic        supply_ok = 1'b0, peak_clr = 1'b0;
    logic        rchg_req;
    logic [3:0]  sample_hist;
    logic [15:0] peak_safe;

    int total = 0, bad = 0, cycles = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    recharge_sched dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pd_mode(pd_mode),
        .adapt_en(adapt_en), .gain_a(gain_a), .gain_b(gain_b),
        .init_man(init_man), .init_exp(init_exp),
        .cap_man(cap_man), .cap_exp(cap_exp),
        .supply_ok(supply_ok), .peak_clr(peak_clr),
        .rchg_req(rchg_req), .sample_hist(sample_hist), .peak_safe(peak_safe)
    );

    task automatic check(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pd_mode = 1'b0; tick = 1'b0; peak_clr = 1'b0;
        adapt_en = 1'b0; gain_a = 4'd1; gain_b = 4'd2;
        init_man = '0; init_exp = '0; cap_man = 5'd31; cap_exp = 3'd6;
        supply_ok = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic enter_pd();
        @(negedge clk);
        pd_mode = 1'b1;
        @(negedge clk);
    endtask

    // ticks until the first request (0 if none within limit)
    task automatic ticks_to_req(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (rchg_req) begin
                n = i;
                break;
            end
            @(negedge clk);
            if (rchg_req) begin
                check("R1 extra-cycle pulse", 1, 0);
            end
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 reset req", rchg_req, 0);
        check("R5 reset hist", sample_hist, 0);
        check("R6 reset peak", peak_safe, 0);
    endtask

    task automatic t_decode();
        int n;
        do_reset();
        enter_pd();
        ticks_to_req(100, n);
        check("R1 period code 0/0", n, 15);
        @(negedge clk);
        check("R1 single-cycle pulse", rchg_req, 0);
        ticks_to_req(100, n);
        check("R1 repeat period", n, 15);
        do_reset();
        init_man = 5'd1; init_exp = 3'd1;
        enter_pd();
        ticks_to_req(200, n);
        check("R1 period code 1/1", n, 62);
    endtask

    task automatic t_adapt();
        int n;
        do_reset();
        adapt_en = 1'b1; supply_ok = 1'b1;
        enter_pd();
        ticks_to_req(100, n);
        check("R1 first interval", n, 15);
        check("R6 peak after good", peak_safe, 15);
        check("R5 hist after good", sample_hist, 1);
        supply_ok = 1'b0;
        ticks_to_req(100, n);
        check("R3 grown interval", n, 25);
        check("R6 peak kept on bad", peak_safe, 15);
        check("R5 hist after bad", sample_hist, 2);
        supply_ok = 1'b1;
        ticks_to_req(100, n);
        check("R3 shrunk interval", n, 7);
        check("R5 hist third", sample_hist, 5);
        // R7: reload on re-entry
        @(negedge clk); pd_mode = 1'b0;
        @(negedge clk);
        check("R9 hist held out of pd", sample_hist, 5);
        enter_pd();
        supply_ok = 1'b0;
        ticks_to_req(100, n);
        check("R7 reload start", n, 15);
    endtask

    task automatic t_zero_gain();
        int n;
        do_reset();
        adapt_en = 1'b1; gain_a = 4'd10; gain_b = 4'd10; supply_ok = 1'b1;
        enter_pd();
        ticks_to_req(100, n);
        ticks_to_req(100, n);
        check("R4 zero step unchanged", n, 15);
        adapt_en = 1'b0; gain_a = 4'd1; gain_b = 4'd2;
        ticks_to_req(100, n);
        check("R4 adapt off unchanged", n, 15);
    endtask

    task automatic t_cap();
        int n;
        do_reset();
        init_man = 5'd1; cap_man = 5'd0; cap_exp = 3'd0;
        adapt_en = 1'b1; supply_ok = 1'b1;
        enter_pd();
        ticks_to_req(100, n);
        check("R2 start clamped", n, 15);
        ticks_to_req(100, n);
        check("R2 growth clamped", n, 15);
    endtask

    task automatic t_floor();
        int n;
        do_reset();
        adapt_en = 1'b1; supply_ok = 1'b0;
        enter_pd();
        ticks_to_req(100, n);
        ticks_to_req(100, n);
        check("R3 shrink 15->5", n, 5);
        ticks_to_req(100, n);
        check("R3 shrink 5->2", n, 2);
        ticks_to_req(100, n);
        check("R10 shrink 2->1", n, 1);
        ticks_to_req(100, n);
        check("R10 floor at 1", n, 1);
    endtask

    task automatic t_peak_clear();
        int n;
        do_reset();
        supply_ok = 1'b1;
        enter_pd();
        ticks_to_req(100, n);
        check("R6 peak set", peak_safe, 15);
        peak_clr = 1'b1;
        @(negedge clk);
        peak_clr = 1'b0;
        check("R6 peak cleared", peak_safe, 0);
        // clear on the same cycle as a good recharge: clear wins
        for (int i = 1; i < 15; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
        tick = 1'b1; peak_clr = 1'b1;
        @(negedge clk);
        tick = 1'b0; peak_clr = 1'b0;
        check("R6 same-cycle pulse", rchg_req, 1);
        check("R6 clear wins", peak_safe, 0);
    endtask

    task automatic t_disabled();
        int n;
        do_reset();
        cap_man = 5'd31; cap_exp = 3'd7;
        enter_pd();
        ticks_to_req(300, n);
        check("R8 no recharge when disabled", n, 0);
    endtask

    task automatic t_idle();
        int n;
        do_reset();
        ticks_to_req(60, n);
        check("R9 no recharge outside pd", n, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_decode();
        t_adapt();
        t_zero_gain();
        t_cap();
        t_floor();
        t_peak_clear();
        t_disabled();
        t_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule